// File: doc/BRIEF.md
# Interrupt-Started Descriptor Transfer Engine

This block moves single bytes on behalf of interrupt sources, with no processor involved. Each source owns one control record in a fixed region of memory. When a source's flag is raised and its activation enable is set, the engine takes the highest-priority waiting source and loads that source's record. It copies one byte from the record's source address to its destination address. It then steps the addresses and the count and stores the record back. A record can ask for the record after it to be run in the same activation. Only the first record of the activation decides what gets cleared at the end: either the source's request flag or its activation enable.

The engine drives one plain synchronous byte memory port, which is used for both records and data. Read data is returned in the cycle after the read request, and the port has no back-pressure. Each source provides a flag input and an enable input. The engine answers with one-cycle clear pulses on `clr_flag` or `clr_en`, and the source logic uses these to drop its flag or its enable. Activation has no global mask or per-source interrupt-priority inputs, so it runs whatever the processor's interrupt state is. A chain stops at the last record even when that record's chain bit is set.

Top module: `desc_xfer_ctrl`

## Requirements
- R1: After reset, `busy` is 0, `mem_req` is 0 and no clear pulse is issued.
- R2: A source is a candidate only while its flag and its enable are both 1. Among the candidates, the lowest index is served first. A source whose enable is 0 never starts an activation.
- R3: The record for source or record i starts at REC_BASE + 8*i and is laid out as follows. Byte 0 is control: bit0 selects repeat mode, bit1 enables chaining, bit2 is repeat-interrupt, bit3 increments the source address, bit4 increments the destination address. Byte 1 is the count. Byte 2 is the repeat size. Bytes 3-4 hold the source address and bytes 5-6 the destination address, each low byte first.
- R4: One activation of a record reads the byte at the source address and writes it to the destination address. Each address then either gains 1 or stays the same, according to its increment bit. The count drops by 1, and the updated record is written back.
- R5: A count of 0 before a transfer means 256, so it becomes 255 afterwards.
- R6: In normal mode, a transfer that takes the count to 0 causes a `clr_en` pulse for the source and no `clr_flag` pulse.
- R7: In repeat mode, a transfer that would take the count to 0 reloads the count from the repeat size. Each incrementing address is moved back by the repeat size, where a size of 0 counts as 256. The end pulse is `clr_en` if repeat-interrupt is 1 and `clr_flag` otherwise.
- R8: Every other outcome ends the activation with a `clr_flag` pulse, and the source's enable stays set.
- R9: When a record's chain bit is set, record i+1 is processed in the same activation. The clear decision comes from the first record alone.
- R10: `busy` is high from the first record read until the final write-back. Exactly one clear pulse follows, in the cycle where `busy` is low.
- R11: A request raised while the engine is busy is held, even if its flag drops again. It is served after the current activation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_flag | input | NSRC | Request flag of each source |
| src_en | input | NSRC | Activation enable of each source |
| clr_flag | output | NSRC | One-cycle pulse that clears a source flag |
| clr_en | output | NSRC | One-cycle pulse that clears a source enable |
| busy | output | 1 | Activation in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write strobe (read when 0) |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after a read request |

## Verification
The transfer path is run with several record contents. These cover both addresses incrementing, both addresses fixed, a starting count of 0, repeat mode with a small and with a zero repeat size, and a two-record chain. Between them, these patterns separate increment from hold, wrap from stop, reload from stop, and first-record from last-record clear decisions. Two sources raised together check the priority order. A disabled source checks the enable gate, and a flag pulse during a busy activation checks that pending requests are held.

// File: rtl/dxc_pkg.sv
package dxc_pkg;
  localparam int REC_BYTES = 7;
  localparam int CB_REPEAT = 0;
  localparam int CB_CHAIN  = 1;
  localparam int CB_RINT   = 2;
  localparam int CB_SINC   = 3;
  localparam int CB_DINC   = 4;

  typedef enum logic [3:0] {
    S_IDLE, S_RREQ, S_RCAP, S_DRD, S_DCAP, S_DWR, S_UPD, S_WB, S_DONE
  } dxc_state_e;
endpackage

// File: rtl/dxc_prio_pick.sv
module dxc_prio_pick #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/dxc_rec_update.sv
module dxc_rec_update import dxc_pkg::*; #(
  parameter int AW = 16
) (
  input  logic [7:0]    ctrl,
  input  logic [7:0]    cnt,
  input  logic [7:0]    rsz,
  input  logic [AW-1:0] sa,
  input  logic [AW-1:0] da,
  output logic [7:0]    cnt_n,
  output logic [AW-1:0] sa_n,
  output logic [AW-1:0] da_n,
  output logic          kill_en
);
  logic          rpt, last, wrap;
  logic [AW-1:0] span, sa_i, da_i;

  always_comb begin
    rpt   = ctrl[CB_REPEAT];
    last  = (cnt == 8'd1);
    wrap  = rpt && last;
    span  = (rsz == 8'd0) ? AW'(256) : AW'(rsz);
    sa_i  = sa + AW'(1);
    da_i  = da + AW'(1);
    cnt_n = wrap ? rsz : cnt - 8'd1;
    sa_n  = !ctrl[CB_SINC] ? sa : (wrap ? sa_i - span : sa_i);
    da_n  = !ctrl[CB_DINC] ? da : (wrap ? da_i - span : da_i);
    kill_en = last && (!rpt || ctrl[CB_RINT]);
  end
endmodule

// File: rtl/desc_xfer_ctrl.sv
module desc_xfer_ctrl import dxc_pkg::*; #(
  parameter int NSRC       = 8,
  parameter int NREC       = 24,
  parameter int AW         = 16,
  parameter int REC_BASE   = 'h0800,
  parameter int REC_STRIDE = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_flag,
  input  logic [NSRC-1:0] src_en,
  output logic [NSRC-1:0] clr_flag,
  output logic [NSRC-1:0] clr_en,
  output logic            busy,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [7:0]      mem_wdata,
  input  logic [7:0]      mem_rdata
);
  localparam int IW = (NREC > 1) ? $clog2(NREC) : 1;
  localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int BW = $clog2(REC_BYTES);

  dxc_state_e      state;
  logic [IW-1:0]   cur_idx;
  logic [SW-1:0]   src_idx;
  logic [BW-1:0]   bcnt;
  logic [7:0]      rec_q [REC_BYTES];
  logic [7:0]      xbyte_q;
  logic            first_q, kill_q;
  logic [NSRC-1:0] pend_q, req_vec, done_mask;
  logic            win_any;
  logic [SW-1:0]   win_idx;
  logic [AW-1:0]   rec_addr, sa, da, sa_n, da_n;
  logic [7:0]      cnt_n;
  logic            kill_en;

  assign req_vec   = pend_q | (src_flag & src_en);
  assign done_mask = (state == S_DONE) ? (NSRC'(1) << src_idx) : '0;
  assign rec_addr  = AW'(REC_BASE) + AW'(cur_idx) * AW'(REC_STRIDE);
  assign sa        = {rec_q[4], rec_q[3]};
  assign da        = {rec_q[6], rec_q[5]};

  dxc_prio_pick #(.N(NSRC)) u_pick (.req(req_vec), .any(win_any), .idx(win_idx));

  dxc_rec_update #(.AW(AW)) u_upd (
    .ctrl(rec_q[0]), .cnt(rec_q[1]), .rsz(rec_q[2]), .sa(sa), .da(da),
    .cnt_n(cnt_n), .sa_n(sa_n), .da_n(da_n), .kill_en(kill_en)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cur_idx <= '0;
      src_idx <= '0;
      bcnt    <= '0;
      xbyte_q <= '0;
      first_q <= 1'b0;
      kill_q  <= 1'b0;
      pend_q  <= '0;
      for (int k = 0; k < REC_BYTES; k++) rec_q[k] <= '0;
    end else begin
      pend_q <= req_vec & ~done_mask;
      case (state)
        S_IDLE: if (win_any) begin
          src_idx <= win_idx;
          cur_idx <= IW'(win_idx);
          first_q <= 1'b1;
          bcnt    <= '0;
          state   <= S_RREQ;
        end
        S_RREQ: state <= S_RCAP;
        S_RCAP: begin
          rec_q[bcnt] <= mem_rdata;
          if (bcnt == BW'(REC_BYTES - 1)) begin
            bcnt  <= '0;
            state <= S_DRD;
          end else begin
            bcnt  <= bcnt + BW'(1);
            state <= S_RREQ;
          end
        end
        S_DRD:  state <= S_DCAP;
        S_DCAP: begin
          xbyte_q <= mem_rdata;
          state   <= S_DWR;
        end
        S_DWR:  state <= S_UPD;
        S_UPD: begin
          rec_q[1] <= cnt_n;
          rec_q[3] <= sa_n[7:0];
          rec_q[4] <= sa_n[15:8];
          rec_q[5] <= da_n[7:0];
          rec_q[6] <= da_n[15:8];
          if (first_q) kill_q <= kill_en;
          bcnt  <= '0;
          state <= S_WB;
        end
        S_WB: begin
          if (bcnt == BW'(REC_BYTES - 1)) begin
            bcnt <= '0;
            if (rec_q[0][CB_CHAIN] && cur_idx != IW'(NREC - 1)) begin
              cur_idx <= cur_idx + IW'(1);
              first_q <= 1'b0;
              state   <= S_RREQ;
            end else begin
              state <= S_DONE;
            end
          end else begin
            bcnt <= bcnt + BW'(1);
          end
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      S_RREQ: begin
        mem_req  = 1'b1;
        mem_addr = rec_addr + AW'(bcnt);
      end
      S_DRD: begin
        mem_req  = 1'b1;
        mem_addr = sa;
      end
      S_DWR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = da;
        mem_wdata = xbyte_q;
      end
      S_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = rec_addr + AW'(bcnt);
        mem_wdata = rec_q[bcnt];
      end
      default: ;
    endcase
  end

  assign busy     = (state != S_IDLE) && (state != S_DONE);
  assign clr_en   = kill_q ? done_mask : '0;
  assign clr_flag = kill_q ? '0 : done_mask;
endmodule

// File: rtl/dxc_chk.sv
module dxc_chk #(
  parameter int NSRC = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            mem_req,
  input logic            mem_we,
  input logic [NSRC-1:0] clr_flag,
  input logic [NSRC-1:0] clr_en
);
  // R10
  mem_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  // R10
  end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (|(clr_flag | clr_en)));

  // R10
  pulse_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_flag | clr_en)) |-> !busy);

  // R8
  single_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clr_flag, clr_en}));

  // R4
  write_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req);

  // R10
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_flag | clr_en)) |=> (clr_flag == '0 && clr_en == '0));
endmodule

bind desc_xfer_ctrl dxc_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req(mem_req),
  .mem_we(mem_we), .clr_flag(clr_flag), .clr_en(clr_en)
);

// File: tb/sim_desc_xfer_ctrl.sv
`timescale 1ns/1ps
module sim_desc_xfer_ctrl;
  localparam int NSRC = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] src_flag, src_en, clr_flag, clr_en;
  logic [NSRC-1:0] set_flag = '0, drop_flag = '0, set_en = '0;
  logic            busy, mem_req, mem_we;
  logic [15:0]     mem_addr;
  logic [7:0]      mem_wdata, mem_rdata;
  logic [7:0]      mem [4096];
  int              nflag [NSRC];
  int              nen [NSRC];
  int              serve_log [64];
  int              nserv;
  int              tests = 0, fails = 0;
  bit              busy_seen;

  always #2.5 clk = ~clk;

  desc_xfer_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .src_flag(src_flag), .src_en(src_en),
    .clr_flag(clr_flag), .clr_en(clr_en), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[11:0]];
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      src_flag <= '0;
      src_en   <= '0;
      nserv    <= 0;
      busy_seen <= 1'b0;
      for (int i = 0; i < NSRC; i++) begin
        nflag[i] <= 0;
        nen[i]   <= 0;
      end
    end else begin
      src_flag <= (src_flag | set_flag) & ~drop_flag & ~clr_flag;
      src_en   <= (src_en | set_en) & ~clr_en;
      if (busy) busy_seen <= 1'b1;
      for (int i = 0; i < NSRC; i++) begin
        if (clr_flag[i]) nflag[i] <= nflag[i] + 1;
        if (clr_en[i])   nen[i]   <= nen[i] + 1;
        if (clr_flag[i] || clr_en[i]) begin
          serve_log[nserv] <= i;
          nserv <= nserv + 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  function automatic int rbase(input int i);
    return 'h800 + 8 * i;
  endfunction

  task automatic put_rec(input int i, input logic [7:0] ctrl, input logic [7:0] cnt,
                         input logic [7:0] rsz, input logic [15:0] sa, input logic [15:0] da);
    mem[rbase(i)]     = ctrl;
    mem[rbase(i) + 1] = cnt;
    mem[rbase(i) + 2] = rsz;
    mem[rbase(i) + 3] = sa[7:0];
    mem[rbase(i) + 4] = sa[15:8];
    mem[rbase(i) + 5] = da[7:0];
    mem[rbase(i) + 6] = da[15:8];
  endtask

  function automatic int rd16(input int a);
    return {mem[a + 1], mem[a]};
  endfunction

  task automatic fire(input logic [NSRC-1:0] m);
    @(negedge clk) set_flag = m;
    @(negedge clk) set_flag = '0;
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (!busy && t < 200) begin @(negedge clk); t++; end
    chk(busy, req, busy, 1);
    t = 0;
    while (busy && t < 2000) begin @(negedge clk); t++; end
    chk(!busy, req, busy, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    chk_eq("R1 busy", busy, 0);
    chk_eq("R1 mem_req", mem_req, 0);
    chk_eq("R1 clears", {clr_flag, clr_en}, 0);
  endtask

  task automatic t_normal_inc();
    int f0 = nflag[0], e0 = nen[0];
    put_rec(0, 8'h18, 8'd3, 8'd0, 16'h0100, 16'h0200);
    mem['h100] = 8'hA5;
    mem['h200] = 8'h00;
    fire(8'h01);
    wait_done("R4 activity");
    chk_eq("R4 data", mem['h200], 'hA5);
    chk_eq("R4 count", mem[rbase(0) + 1], 2);
    chk_eq("R4 src inc", rd16(rbase(0) + 3), 'h101);
    chk_eq("R4 dst inc", rd16(rbase(0) + 5), 'h201);
    chk_eq("R8 flag clear", nflag[0] - f0, 1);
    chk_eq("R8 enable kept", nen[0] - e0, 0);
    chk_eq("R3 ctrl kept", mem[rbase(0)], 'h18);
  endtask

  task automatic t_normal_fixed_end();
    int f1 = nflag[1], e1 = nen[1];
    put_rec(1, 8'h00, 8'd1, 8'd9, 16'h0110, 16'h0210);
    mem['h110] = 8'h3C;
    fire(8'h02);
    wait_done("R6 activity");
    chk_eq("R4 fixed data", mem['h210], 'h3C);
    chk_eq("R4 src fixed", rd16(rbase(1) + 3), 'h110);
    chk_eq("R4 dst fixed", rd16(rbase(1) + 5), 'h210);
    chk_eq("R6 count zero", mem[rbase(1) + 1], 0);
    chk_eq("R6 enable clear", nen[1] - e1, 1);
    chk_eq("R6 no flag clear", nflag[1] - f1, 0);
    chk_eq("R6 enable low", src_en[1], 0);
  endtask

  task automatic t_zero_count();
    int f5 = nflag[5];
    put_rec(5, 8'h08, 8'd0, 8'd0, 16'h0120, 16'h0220);
    mem['h120] = 8'h5A;
    fire(8'h20);
    wait_done("R5 activity");
    chk_eq("R5 count 256", mem[rbase(5) + 1], 255);
    chk_eq("R5 src inc", rd16(rbase(5) + 3), 'h121);
    chk_eq("R5 flag clear", nflag[5] - f5, 1);
  endtask

  task automatic t_repeat_noint();
    int f7 = nflag[7], e7 = nen[7];
    put_rec(7, 8'h09, 8'd1, 8'd2, 16'h0105, 16'h0230);
    mem['h105] = 8'h77;
    fire(8'h80);
    wait_done("R7 activity");
    chk_eq("R7 data", mem['h230], 'h77);
    chk_eq("R7 reload", mem[rbase(7) + 1], 2);
    chk_eq("R7 src restore", rd16(rbase(7) + 3), 'h104);
    chk_eq("R7 dst fixed", rd16(rbase(7) + 5), 'h230);
    chk_eq("R7 flag clear", nflag[7] - f7, 1);
    chk_eq("R7 enable kept", nen[7] - e7, 0);
  endtask

  task automatic t_repeat_int();
    int f7 = nflag[7], e7 = nen[7];
    put_rec(7, 8'h15, 8'd1, 8'd0, 16'h0140, 16'h0340);
    mem['h140] = 8'h11;
    fire(8'h80);
    wait_done("R7 int activity");
    chk_eq("R7 int data", mem['h340], 'h11);
    chk_eq("R7 int reload", mem[rbase(7) + 1], 0);
    chk_eq("R7 int dst restore", rd16(rbase(7) + 5), 'h241);
    chk_eq("R7 int enable clear", nen[7] - e7, 1);
    chk_eq("R7 int no flag", nflag[7] - f7, 0);
  endtask

  task automatic t_priority();
    int n0;
    @(negedge clk) set_en = 8'h02;
    @(negedge clk) set_en = '0;
    put_rec(1, 8'h00, 8'd5, 8'd0, 16'h0111, 16'h0211);
    put_rec(3, 8'h00, 8'd5, 8'd0, 16'h0113, 16'h0213);
    mem['h111] = 8'hC1;
    mem['h113] = 8'hC3;
    n0 = nserv;
    fire(8'h0A);
    wait_done("R2 first");
    wait_done("R2 second");
    chk_eq("R2 served count", nserv - n0, 2);
    chk_eq("R2 first served", serve_log[n0], 1);
    chk_eq("R2 second served", serve_log[n0 + 1], 3);
    chk_eq("R2 data3", mem['h213], 'hC3);
  endtask

  task automatic t_disabled();
    int n0 = nserv;
    put_rec(2, 8'h00, 8'd5, 8'd0, 16'h0112, 16'h0212);
    mem['h112] = 8'hEE;
    mem['h212] = 8'h00;
    @(negedge clk) busy_seen = 1'b0;
    fire(8'h04);
    repeat (60) @(negedge clk);
    chk_eq("R2 disabled idle", busy_seen, 0);
    chk_eq("R2 disabled no data", mem['h212], 0);
    chk_eq("R2 disabled no clear", nserv - n0, 0);
    @(negedge clk) drop_flag = 8'h04;
    @(negedge clk) drop_flag = '0;
  endtask

  task automatic t_chain();
    int f4 = nflag[4], e4 = nen[4], f5 = nflag[5], e5 = nen[5];
    put_rec(4, 8'h1A, 8'd4, 8'd0, 16'h0150, 16'h0250);
    put_rec(5, 8'h00, 8'd1, 8'd0, 16'h0160, 16'h0260);
    mem['h150] = 8'h44;
    mem['h160] = 8'h55;
    fire(8'h10);
    wait_done("R9 activity");
    chk_eq("R9 first data", mem['h250], 'h44);
    chk_eq("R9 second data", mem['h260], 'h55);
    chk_eq("R9 first count", mem[rbase(4) + 1], 3);
    chk_eq("R9 second count", mem[rbase(5) + 1], 0);
    chk_eq("R9 flag clear first", nflag[4] - f4, 1);
    chk_eq("R9 no enable clear", nen[4] - e4, 0);
    chk_eq("R9 chained untouched", (nflag[5] - f5) + (nen[5] - e5), 0);
  endtask

  task automatic t_latch();
    int n0;
    put_rec(6, 8'h00, 8'd5, 8'd0, 16'h0170, 16'h0270);
    put_rec(0, 8'h00, 8'd5, 8'd0, 16'h0180, 16'h0280);
    mem['h180] = 8'h99;
    mem['h280] = 8'h00;
    n0 = nserv;
    fire(8'h40);
    while (!busy) @(negedge clk);
    repeat (3) @(negedge clk);
    fire(8'h01);
    @(negedge clk) drop_flag = 8'h01;
    @(negedge clk) drop_flag = '0;
    chk_eq("R11 still busy", busy, 1);
    wait_done("R11 first");
    wait_done("R11 held");
    chk_eq("R11 order a", serve_log[n0], 6);
    chk_eq("R11 order b", serve_log[n0 + 1], 0);
    chk_eq("R11 held data", mem['h280], 'h99);
  endtask

  initial begin
    for (int a = 0; a < 4096; a++) mem[a] = 8'h00;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk) set_en = 8'hFB;
    @(negedge clk) set_en = '0;
    t_normal_inc();
    t_normal_fixed_end();
    t_zero_count();
    t_repeat_noint();
    t_repeat_int();
    t_priority();
    t_disabled();
    t_chain();
    t_latch();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule